// File: doc/BRIEF.md
# Paged Program Address Extender

This block widens a 16-bit program counter into a 20-bit program-memory address by placing a 4-bit page number above it. The program space is split into 16 pages of 64K words each. The page register also appears in data space at address 0x001E, so the core reads and writes it as an ordinary memory-mapped register. Reset clears it to page 0.

Control flow arrives on a command port with a valid/ready handshake. A command is taken in any cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops for exactly one cycle after a far call or far return is taken, because those commands move two stack words. While `cmd_ready` is low, the source must hold its command and keep it stable. No command is taken while `cmd_valid` is low, and the counter and page keep their values.

Most commands stay inside the current page: step, near branch, near call, near return and interrupt entry. Far branches and far calls load both the page and the counter from a 20-bit target, taken either from the command or from the low 20 bits of an accumulator. Far returns restore both from the stack. Table reads and writes form a transient 20-bit access address from an accumulator and leave the page alone. The stack memory sits outside the block and is reached through a push/pop port.

Top module: `pgx_extender`

## Requirements
- R1: After reset, `fetch_addr` is 0, `cmd_ready` is 1, `tbl_rd`, `tbl_wr`, `ie_set`, `stk_push` and `stk_pop` are 0, and a read at 0x001E returns 0.
- R2: `fetch_addr` is {page, pc}. A step (kind 0) adds 1 to pc and wraps from 0xFFFF to 0x0000 without changing the page. The new value shows in the cycle after the command is taken.
- R3: A data write (`mmr_we`) to 0x001E loads the page from `mmr_wdata[3:0]`, and writes to other addresses do not change it. A read at 0x001E returns the page zero-extended to 16 bits. A read at any other address returns 0.
- R4: A far branch (kind 5) loads the page from `cmd_target[19:16]` and pc from `cmd_target[15:0]`, visible in the cycle after it is taken.
- R5: The accumulator far branch (kind 6) and accumulator far call (kind 8) use accumulator A when `cmd_acc_sel` is 0 and accumulator B when it is 1, as the full 20-bit target.
- R6: A far call (kind 7, or kind 8) pushes the current page, zero-extended, in the cycle it is taken. In the next cycle, with `cmd_ready` low, it pushes the return pc (pc+1). After that second cycle the target takes effect.
- R7: A far return (kind 9) pops the return pc in the cycle it is taken and pops the page in the next cycle, with `cmd_ready` low. Both take effect together after that second cycle. The variant with interrupt enable (kind 10) also raises `ie_set` during that second cycle, and kind 9 never does.
- R8: Near branch (1), near call (2), near return (3) and interrupt entry (4) never change the page. The near call pushes pc+1. The interrupt pushes the current pc and jumps to `cmd_target[15:0]`. The near return loads pc from the popped word.
- R9: A table read (kind 11) or table write (kind 12) raises `tbl_rd` or `tbl_wr` for one cycle, in the cycle after it is taken. In that cycle `tbl_addr` equals the selected accumulator's 20 bits. The page and pc are not changed.
- R10: When a far command loads the page in the same cycle as a data write to 0x001E, the far command's page is kept.
- R11: While `cmd_ready` is low, a held command is not taken. It is taken on the first cycle `cmd_ready` returns high. When `cmd_valid` is low, `fetch_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_kind | input | 4 | Command code (see requirements) |
| cmd_target | input | 20 | Immediate target address |
| cmd_acc_sel | input | 1 | 0 selects accumulator A, 1 selects B |
| acc_a | input | 20 | Low 20 bits of accumulator A |
| acc_b | input | 20 | Low 20 bits of accumulator B |
| mmr_addr | input | 16 | Data-space register address |
| mmr_we | input | 1 | Data-space write enable |
| mmr_wdata | input | 16 | Data-space write data |
| mmr_rdata | output | 16 | Data-space read data |
| stk_push | output | 1 | Push `stk_wdata` onto the stack |
| stk_pop | output | 1 | Pop the stack top |
| stk_wdata | output | 16 | Word to push |
| stk_rdata | input | 16 | Current stack top |
| ie_set | output | 1 | Enable interrupts (far return variant) |
| fetch_addr | output | 20 | Extended fetch address |
| tbl_addr | output | 20 | Extended table-access address |
| tbl_rd | output | 1 | Table read strobe |
| tbl_wr | output | 1 | Table write strobe |

## Verification
A wrong page value shows in the top four bits of `fetch_addr` and in the 0x001E read in the very next cycle, so every scenario reads both back right after each command. A stuck sequencer state shows as `cmd_ready` staying low for more than one cycle, or as a push or pop in the wrong cycle. The bench models the stack and checks each pushed word against the page and pc it expects. A return that restores the page and pc out of step leaves a mixed address visible for one cycle. For that reason far returns are sampled in the cycle right after the second pop.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [3:0] {
    CMD_STEP  = 4'd0,
    CMD_BR    = 4'd1,
    CMD_CALL  = 4'd2,
    CMD_RET   = 4'd3,
    CMD_INTR  = 4'd4,
    CMD_FBR   = 4'd5,
    CMD_FBACC = 4'd6,
    CMD_FCALL = 4'd7,
    CMD_FCALA = 4'd8,
    CMD_FRET  = 4'd9,
    CMD_FRETE = 4'd10,
    CMD_TRD   = 4'd11,
    CMD_TWR   = 4'd12
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALL2 = 2'd1,
    ST_RET2  = 2'd2
  } flow_st_e;
endpackage

// File: rtl/pgx_acc_sel.sv
module pgx_acc_sel #(
  parameter int ADDR_W = 20
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] acc_a,
  input  logic [ADDR_W-1:0] acc_b,
  output logic [ADDR_W-1:0] acc_addr
);
  assign acc_addr = sel ? acc_b : acc_a;
endmodule

// File: rtl/pgx_page_reg.sv
module pgx_page_reg #(
  parameter int          PAGE_W   = 4,
  parameter int          DATA_W   = 16,
  parameter int          MADDR_W  = 16,
  parameter logic [15:0] MMR_ADDR = 16'h001E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MADDR_W-1:0] mmr_addr,
  input  logic               mmr_we,
  input  logic [DATA_W-1:0]  mmr_wdata,
  output logic [DATA_W-1:0]  mmr_rdata,
  input  logic               far_ld,
  input  logic [PAGE_W-1:0]  far_page,
  output logic [PAGE_W-1:0]  page_q
);
  localparam logic [MADDR_W-1:0] HIT_ADDR = MADDR_W'(MMR_ADDR);

  logic hit;
  assign hit = (mmr_addr == HIT_ADDR);

  // far load has priority over a same-cycle data write
  always_ff @(posedge clk) begin
    if (!rst_n)
      page_q <= '0;
    else if (far_ld)
      page_q <= far_page;
    else if (mmr_we && hit)
      page_q <= PAGE_W'(mmr_wdata);
  end

  assign mmr_rdata = hit ? DATA_W'(page_q) : '0;
endmodule

// File: rtl/pgx_flow.sv
module pgx_flow
  import pgx_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int PC_W   = 16,
  parameter int KIND_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [KIND_W-1:0]        cmd_kind,
  input  logic [PAGE_W+PC_W-1:0]   cmd_target,
  input  logic [PAGE_W+PC_W-1:0]   acc_addr,
  input  logic [PAGE_W-1:0]        page_q,
  output logic                     page_ld,
  output logic [PAGE_W-1:0]        page_nx,
  output logic [PC_W-1:0]          pc_q,
  output logic                     stk_push,
  output logic                     stk_pop,
  output logic [PC_W-1:0]          stk_wdata,
  input  logic [PC_W-1:0]          stk_rdata,
  output logic                     ie_set
);
  localparam int ADDR_W = PAGE_W + PC_W;

  flow_st_e          st_q, st_d;
  logic [PC_W-1:0]   pc_d, hold_pc_q, hold_pc_d, ret_pc;
  logic [ADDR_W-1:0] hold_tgt_q, hold_tgt_d, far_tgt;
  logic              hold_ie_q, hold_ie_d;
  logic              use_acc;

  assign cmd_ready = (st_q == ST_IDLE);
  assign ret_pc    = pc_q + PC_W'(1);
  assign use_acc   = (cmd_kind == CMD_FBACC) || (cmd_kind == CMD_FCALA);
  assign far_tgt   = use_acc ? acc_addr : cmd_target;
  assign ie_set    = (st_q == ST_RET2) && hold_ie_q;

  always_comb begin
    st_d       = st_q;
    pc_d       = pc_q;
    hold_pc_d  = hold_pc_q;
    hold_tgt_d = hold_tgt_q;
    hold_ie_d  = hold_ie_q;
    page_ld    = 1'b0;
    page_nx    = page_q;
    stk_push   = 1'b0;
    stk_pop    = 1'b0;
    stk_wdata  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (cmd_kind)
            CMD_STEP: pc_d = ret_pc;
            CMD_BR:   pc_d = cmd_target[PC_W-1:0];
            CMD_CALL: begin
              stk_push  = 1'b1;
              stk_wdata = ret_pc;
              pc_d      = cmd_target[PC_W-1:0];
            end
            CMD_RET: begin
              stk_pop = 1'b1;
              pc_d    = stk_rdata;
            end
            CMD_INTR: begin
              stk_push  = 1'b1;
              stk_wdata = pc_q;
              pc_d      = cmd_target[PC_W-1:0];
            end
            CMD_FBR, CMD_FBACC: begin
              page_ld = 1'b1;
              page_nx = far_tgt[ADDR_W-1:PC_W];
              pc_d    = far_tgt[PC_W-1:0];
            end
            CMD_FCALL, CMD_FCALA: begin
              stk_push   = 1'b1;
              stk_wdata  = PC_W'(page_q);
              hold_pc_d  = ret_pc;
              hold_tgt_d = far_tgt;
              st_d       = ST_CALL2;
            end
            CMD_FRET, CMD_FRETE: begin
              stk_pop   = 1'b1;
              hold_pc_d = stk_rdata;
              hold_ie_d = (cmd_kind == CMD_FRETE);
              st_d      = ST_RET2;
            end
            default: ;
          endcase
        end
      end
      ST_CALL2: begin
        stk_push  = 1'b1;
        stk_wdata = hold_pc_q;
        page_ld   = 1'b1;
        page_nx   = hold_tgt_q[ADDR_W-1:PC_W];
        pc_d      = hold_tgt_q[PC_W-1:0];
        st_d      = ST_IDLE;
      end
      ST_RET2: begin
        stk_pop = 1'b1;
        page_ld = 1'b1;
        page_nx = PAGE_W'(stk_rdata);
        pc_d    = hold_pc_q;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pc_q       <= '0;
      hold_pc_q  <= '0;
      hold_tgt_q <= '0;
      hold_ie_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      pc_q       <= pc_d;
      hold_pc_q  <= hold_pc_d;
      hold_tgt_q <= hold_tgt_d;
      hold_ie_q  <= hold_ie_d;
    end
  end
endmodule

// File: rtl/pgx_tbl_port.sv
module pgx_tbl_port #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic              tbl_rd,
  output logic              tbl_wr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_addr <= '0;
      tbl_rd   <= 1'b0;
      tbl_wr   <= 1'b0;
    end else begin
      tbl_rd <= go_rd;
      tbl_wr <= go_wr;
      if (go_rd || go_wr)
        tbl_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/pgx_extender.sv
module pgx_extender
  import pgx_pkg::*;
#(
  parameter int          PAGE_W   = 4,
  parameter int          PC_W     = 16,
  parameter int          DATA_W   = 16,
  parameter int          MADDR_W  = 16,
  parameter logic [15:0] MMR_ADDR = 16'h001E,
  localparam int         ADDR_W   = PAGE_W + PC_W,
  localparam int         KIND_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [KIND_W-1:0]  cmd_kind,
  input  logic [ADDR_W-1:0]  cmd_target,
  input  logic               cmd_acc_sel,
  input  logic [ADDR_W-1:0]  acc_a,
  input  logic [ADDR_W-1:0]  acc_b,
  input  logic [MADDR_W-1:0] mmr_addr,
  input  logic               mmr_we,
  input  logic [DATA_W-1:0]  mmr_wdata,
  output logic [DATA_W-1:0]  mmr_rdata,
  output logic               stk_push,
  output logic               stk_pop,
  output logic [PC_W-1:0]    stk_wdata,
  input  logic [PC_W-1:0]    stk_rdata,
  output logic               ie_set,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic               tbl_rd,
  output logic               tbl_wr
);
  logic [ADDR_W-1:0] acc_addr;
  logic [PAGE_W-1:0] page_q, page_nx;
  logic [PC_W-1:0]   pc_q;
  logic              page_ld, take;

  assign take = cmd_valid && cmd_ready;

  pgx_acc_sel #(.ADDR_W(ADDR_W)) u_acc (
    .sel      (cmd_acc_sel),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .acc_addr (acc_addr)
  );

  pgx_page_reg #(
    .PAGE_W(PAGE_W), .DATA_W(DATA_W), .MADDR_W(MADDR_W), .MMR_ADDR(MMR_ADDR)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .mmr_addr  (mmr_addr),
    .mmr_we    (mmr_we),
    .mmr_wdata (mmr_wdata),
    .mmr_rdata (mmr_rdata),
    .far_ld    (page_ld),
    .far_page  (page_nx),
    .page_q    (page_q)
  );

  pgx_flow #(.PAGE_W(PAGE_W), .PC_W(PC_W), .KIND_W(KIND_W)) u_flow (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_kind   (cmd_kind),
    .cmd_target (cmd_target),
    .acc_addr   (acc_addr),
    .page_q     (page_q),
    .page_ld    (page_ld),
    .page_nx    (page_nx),
    .pc_q       (pc_q),
    .stk_push   (stk_push),
    .stk_pop    (stk_pop),
    .stk_wdata  (stk_wdata),
    .stk_rdata  (stk_rdata),
    .ie_set     (ie_set)
  );

  pgx_tbl_port #(.ADDR_W(ADDR_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_rd    (take && (cmd_kind == CMD_TRD)),
    .go_wr    (take && (cmd_kind == CMD_TWR)),
    .acc_addr (acc_addr),
    .tbl_addr (tbl_addr),
    .tbl_rd   (tbl_rd),
    .tbl_wr   (tbl_wr)
  );

  assign fetch_addr = {page_q, pc_q};
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [3:0]  cmd_kind,
  input logic [19:0] cmd_target,
  input logic [15:0] mmr_addr,
  input logic        mmr_we,
  input logic [15:0] mmr_rdata,
  input logic        stk_push,
  input logic        stk_pop,
  input logic        ie_set,
  input logic [19:0] fetch_addr,
  input logic        tbl_rd,
  input logic        tbl_wr
);
  logic take, page_wr;
  assign take    = cmd_valid && cmd_ready;
  assign page_wr = mmr_we && (mmr_addr == 16'h001E);

  a_r2_step_wraps_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind == 4'd0 && !page_wr) |=>
      (fetch_addr == {$past(fetch_addr[19:16]), 16'($past(fetch_addr[15:0]) + 16'd1)}));

  a_r3_read_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (mmr_addr == 16'h001E) |-> (mmr_rdata == {12'h000, fetch_addr[19:16]}));

  a_r6_no_push_and_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));

  a_r7_ie_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ie_set |-> (stk_pop && !cmd_ready));

  a_r8_near_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind >= 4'd1 && cmd_kind <= 4'd4 && !page_wr) |=>
      $stable(fetch_addr[19:16]));

  a_r9_table_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind == 4'd11) |=> (tbl_rd && !tbl_wr));

  a_r10_far_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind == 4'd5 && page_wr) |=> (fetch_addr == $past(cmd_target)));

  a_r11_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);
endmodule

bind pgx_extender pgx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_kind   (cmd_kind),
  .cmd_target (cmd_target),
  .mmr_addr   (mmr_addr),
  .mmr_we     (mmr_we),
  .mmr_rdata  (mmr_rdata),
  .stk_push   (stk_push),
  .stk_pop    (stk_pop),
  .ie_set     (ie_set),
  .fetch_addr (fetch_addr),
  .tbl_rd     (tbl_rd),
  .tbl_wr     (tbl_wr)
);

// File: tb/pgx_extender_test.sv
module pgx_extender_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_kind = 4'd0;
  logic [19:0] cmd_target = '0;
  logic        cmd_acc_sel = 1'b0;
  logic [19:0] acc_a = '0, acc_b = '0;
  logic [15:0] mmr_addr = '0;
  logic        mmr_we = 1'b0;
  logic [15:0] mmr_wdata = '0;
  logic [15:0] mmr_rdata;
  logic        stk_push, stk_pop, ie_set, tbl_rd, tbl_wr;
  logic [15:0] stk_wdata, stk_rdata;
  logic [19:0] fetch_addr, tbl_addr;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // stack model
  logic [15:0] smem [16];
  int sp = 0;
  assign stk_rdata = (sp > 0) ? smem[sp-1] : 16'h0000;
  always @(posedge clk) begin
    if (stk_push) begin
      smem[sp] <= stk_wdata;
      sp <= sp + 1;
    end else if (stk_pop) begin
      sp <= sp - 1;
    end
  end

  pgx_extender uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_target(cmd_target), .cmd_acc_sel(cmd_acc_sel),
    .acc_a(acc_a), .acc_b(acc_b), .mmr_addr(mmr_addr), .mmr_we(mmr_we),
    .mmr_wdata(mmr_wdata), .mmr_rdata(mmr_rdata), .stk_push(stk_push),
    .stk_pop(stk_pop), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .ie_set(ie_set), .fetch_addr(fetch_addr), .tbl_addr(tbl_addr),
    .tbl_rd(tbl_rd), .tbl_wr(tbl_wr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one command; returns at the falling edge after it is taken
  task automatic send(logic [3:0] k, logic [19:0] tgt, logic sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_target = tgt; cmd_acc_sel = sel;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic mmr_write(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    mmr_addr = a; mmr_we = 1'b1; mmr_wdata = d;
    @(negedge clk);
    mmr_we = 1'b0;
  endtask

  task automatic t_reset;
    mmr_addr = 16'h001E;
    #1;
    chk("R1 fetch", 32'(fetch_addr), 32'h0);
    chk("R1 ready", 32'(cmd_ready), 32'h1);
    chk("R1 strobes", {27'h0, tbl_rd, tbl_wr, ie_set, stk_push, stk_pop}, 32'h0);
    chk("R1 read page", 32'(mmr_rdata), 32'h0);
  endtask

  task automatic t_step_and_mmr;
    send(4'd0, 20'h0, 1'b0);
    send(4'd0, 20'h0, 1'b0);
    send(4'd0, 20'h0, 1'b0);
    chk("R2 step x3", 32'(fetch_addr), 32'h00003);
    mmr_write(16'h001E, 16'hFFF5);
    mmr_addr = 16'h001E; #1;
    chk("R3 read 0x1E", 32'(mmr_rdata), 32'h0005);
    chk("R3 page in fetch", 32'(fetch_addr), 32'h50003);
    mmr_write(16'h001F, 16'h0009);
    mmr_addr = 16'h001E; #1;
    chk("R3 other write ignored", 32'(mmr_rdata), 32'h0005);
    mmr_addr = 16'h001F; #1;
    chk("R3 other read zero", 32'(mmr_rdata), 32'h0000);
    mmr_addr = 16'h001E;
    send(4'd1, 20'h3FFFF, 1'b0);
    chk("R8 near branch keeps page", 32'(fetch_addr), 32'h5FFFF);
    send(4'd0, 20'h0, 1'b0);
    chk("R2 wrap in page", 32'(fetch_addr), 32'h50000);
  endtask

  task automatic t_far_branch;
    send(4'd5, 20'hA1234, 1'b0);
    chk("R4 far branch", 32'(fetch_addr), 32'hA1234);
    #1;
    chk("R4 page read", 32'(mmr_rdata), 32'h000A);
    acc_a = 20'h70001; acc_b = 20'h3BEEF;
    send(4'd6, 20'h00000, 1'b1);
    chk("R5 acc B far branch", 32'(fetch_addr), 32'h3BEEF);
    send(4'd6, 20'h00000, 1'b0);
    chk("R5 acc A far branch", 32'(fetch_addr), 32'h70001);
  endtask

  task automatic t_far_call_return;
    int base = sp;
    send(4'd7, 20'hC0100, 1'b0);
    chk("R6 ready low", 32'(cmd_ready), 32'h0);
    chk("R6 page pushed", 32'(smem[base]), 32'h0007);
    chk("R6 ret pc push", {15'h0, stk_push, stk_wdata}, {15'h0, 1'b1, 16'h0002});
    chk("R6 not yet jumped", 32'(fetch_addr), 32'h70001);
    @(negedge clk);
    chk("R6 far call target", 32'(fetch_addr), 32'hC0100);
    chk("R6 ready back", 32'(cmd_ready), 32'h1);
    send(4'd10, 20'h0, 1'b0);
    chk("R7 second pop with ie", {30'h0, stk_pop, ie_set}, 32'h3);
    chk("R7 no early restore", 32'(fetch_addr), 32'hC0100);
    @(negedge clk);
    chk("R7 restore both", 32'(fetch_addr), 32'h70002);
    chk("R7 ie one cycle", 32'(ie_set), 32'h0);
    chk("R7 stack balanced", 32'(sp), 32'(base));
  endtask

  task automatic t_near_flow;
    send(4'd2, 20'hF0500, 1'b0);
    chk("R8 near call", 32'(fetch_addr), 32'h70500);
    chk("R8 call pushes pc+1", 32'(stk_rdata), 32'h0003);
    send(4'd3, 20'h0, 1'b0);
    chk("R8 near return", 32'(fetch_addr), 32'h70003);
    send(4'd4, 20'h20040, 1'b0);
    chk("R8 interrupt vector", 32'(fetch_addr), 32'h70040);
    chk("R8 interrupt pushes pc", 32'(stk_rdata), 32'h0003);
    send(4'd3, 20'h0, 1'b0);
    chk("R8 interrupt return", 32'(fetch_addr), 32'h70003);
    acc_a = 20'h20010;
    send(4'd8, 20'h9FFFF, 1'b0);
    @(negedge clk);
    chk("R5 acc A far call", 32'(fetch_addr), 32'h20010);
    send(4'd9, 20'h0, 1'b0);
    chk("R7 plain return no ie", 32'(ie_set), 32'h0);
    @(negedge clk);
    chk("R7 plain far return", 32'(fetch_addr), 32'h70004);
  endtask

  task automatic t_table;
    acc_a = 20'h1_2345; acc_b = 20'hF00AA;
    send(4'd11, 20'h0, 1'b1);
    chk("R9 table read strobe", {30'h0, tbl_rd, tbl_wr}, 32'h2);
    chk("R9 table read addr", 32'(tbl_addr), 32'hF00AA);
    chk("R9 fetch unchanged", 32'(fetch_addr), 32'h70004);
    #1;
    chk("R9 page unchanged", 32'(mmr_rdata), 32'h0007);
    @(negedge clk);
    chk("R9 strobe one cycle", {30'h0, tbl_rd, tbl_wr}, 32'h0);
    send(4'd12, 20'h0, 1'b0);
    chk("R9 table write strobe", {30'h0, tbl_rd, tbl_wr}, 32'h1);
    chk("R9 table write addr", 32'(tbl_addr), 32'h12345);
  endtask

  task automatic t_conflict;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 4'd5; cmd_target = 20'h90000;
    mmr_addr = 16'h001E; mmr_we = 1'b1; mmr_wdata = 16'h0003;
    @(negedge clk);
    cmd_valid = 1'b0; mmr_we = 1'b0;
    chk("R10 far branch beats write", 32'(fetch_addr), 32'h90000);
    send(4'd7, 20'h40000, 1'b0);
    mmr_we = 1'b1; mmr_wdata = 16'h0001;
    @(negedge clk);
    mmr_we = 1'b0;
    chk("R10 far call beats write", 32'(fetch_addr), 32'h40000);
    send(4'd9, 20'h0, 1'b0);
    @(negedge clk);
    chk("R10 return after conflict", 32'(fetch_addr), 32'h90001);
  endtask

  task automatic t_backpressure;
    send(4'd7, 20'h60000, 1'b0);
    cmd_valid = 1'b1; cmd_kind = 4'd0;
    #1;
    chk("R11 held while busy", 32'(cmd_ready), 32'h0);
    @(negedge clk);
    chk("R11 not taken early", 32'(fetch_addr), 32'h60000);
    chk("R11 ready again", 32'(cmd_ready), 32'h1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 held command taken", 32'(fetch_addr), 32'h60001);
    repeat (3) @(negedge clk);
    chk("R11 idle holds", 32'(fetch_addr), 32'h60001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_and_mmr();
    t_far_branch();
    t_far_call_return();
    t_near_flow();
    t_table();
    t_conflict();
    t_backpressure();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule